// File: doc/BRIEF.md
# Time-of-Day Counter with Pulse-Per-Second Output

This block keeps the time of day as two registers: a seconds count and a count of reference-clock cycles within the current second. The cycle count runs at the reference rate (125 MHz by default). When it reaches the last cycle of a second it returns to zero, and the seconds count moves forward by one. Each time the cycle count lands on zero, a pulse of programmable width is driven on a pulse-per-second output.

A host changes the time through a small command interface. The time value is presented on three shadow inputs: a low seconds word, a high seconds byte, and a cycle value. A set command copies the shadow values into the counters at the next clock edge. An adjust command stores the shadow values as a signed offset. The offset is added at the next second boundary, and a busy flag stays high until that has happened. The cycle offset is in reference cycles, so at 125 MHz a value in nanoseconds is divided by eight. A negative cycle offset borrows one second. Clock generation and any servo loop lie outside the block.

Top module: `pps_timekeeper`

## Requirements
- R1: While reset is held, and at the first clock edge after it, seconds and cycles read zero, the pulse output is low and busy is low.
- R2: With the count enable high, the cycle count rises by one per clock. From the value CYCLES_PER_SEC-1 it goes to 0, and seconds rise by one at the same edge. Seconds wrap from all ones to zero.
- R3: With the count enable low, the seconds and cycle counts hold their values, no new pulse starts, and a pending adjust stays pending.
- R4: A set request loads seconds = {high byte, low word} and cycles = shadow cycle value (which must be below CYCLES_PER_SEC) at the next edge, whatever the enable. Set takes priority over a rollover and over an adjust request in the same cycle. Set also discards any pending adjust, so busy reads low after it.
- R5: An adjust request made while not busy captures the shadow values, and busy reads high from the next cycle. An adjust request made while busy is ignored, and the offset captured first is the one applied.
- R6: A pending adjust is applied at the rollover edge. There, seconds become old seconds + 1 + seconds offset (modulo 2^40), and cycles become the cycle offset when that offset is non-negative. Busy reads low after that edge.
- R7: A cycle offset whose top bit (bit 27) is set is a negative two's-complement value. Its magnitude must not exceed one second. At the rollover edge, cycles become CYCLES_PER_SEC plus the offset, and seconds come out one fewer than in R6.
- R8: The pulse output rises in the same cycle the cycle count first reads zero. It stays high for exactly the number of cycles the width input held at that edge. A width of zero gives no pulse, and later changes to the width do not alter a pulse already running.
- R9: A pulse also starts when a set or an applied adjust places the cycle count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Count enable |
| pulse_width | input | PW_W | Pulse length in reference cycles |
| set_req | input | 1 | One-cycle set command |
| adj_req | input | 1 | One-cycle adjust command |
| shadow_sec_lo | input | 32 | Seconds value or offset, low word |
| shadow_sec_hi | input | 8 | Seconds value or offset, high byte |
| shadow_cyc | input | 28 | Cycle value, or signed cycle offset |
| sec_o | output | 40 | Current seconds |
| cyc_o | output | 28 | Current cycle within the second |
| pps_o | output | 1 | Pulse-per-second output |
| busy_o | output | 1 | Adjust pending; low means the last adjust is done |

## Verification
Three events can meet on the last cycle of a second: the natural rollover, the application of a pending adjust, and a host set. The bench provokes each collision with its own cycle-accurate model of the count. It walks the counter to the final cycle of a second, arms an adjust a few cycles earlier, and issues a set exactly on that final cycle. The outcome is judged on the ports. Seconds and cycles must equal the set value rather than the adjusted or rolled-over value, and busy must read low afterwards. A second collision issues an adjust request and a set in the same cycle and checks that busy never rises.

// File: rtl/ppsg_pkg.sv
package ppsg_pkg;

    localparam int CYC_W    = 28;
    localparam int SEC_LO_W = 32;
    localparam int SEC_HI_W = 8;
    localparam int SEC_W    = SEC_LO_W + SEC_HI_W;

    typedef logic [CYC_W-1:0] cyc_t;
    typedef logic [SEC_W-1:0] sec_t;

    typedef struct packed {
        sec_t sec;
        cyc_t cyc;
    } tod_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_RUN,
        OP_ROLL,
        OP_ROLL_ADJ,
        OP_SET
    } tb_op_e;

    // Next time value at a second boundary with a signed offset applied.
    function automatic tod_t roll_with_offset(sec_t sec_now, tod_t delta, cyc_t limit);
        tod_t r;
        r.sec = sec_now + sec_t'(1) + delta.sec;
        if (delta.cyc[CYC_W-1]) begin
            r.cyc = limit + delta.cyc;
            r.sec = r.sec - sec_t'(1);
        end else begin
            r.cyc = delta.cyc;
        end
        return r;
    endfunction

endpackage

// File: rtl/ppsg_timebase.sv
module ppsg_timebase
    import ppsg_pkg::*;
#(
    parameter int unsigned CYCLES_PER_SEC = 125_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic set_stb,
    input  tod_t set_val,
    input  logic adj_pend,
    input  tod_t adj_val,
    output tod_t tod_q,
    output logic adj_applied,
    output logic zero_load
);

    localparam cyc_t LIMIT    = cyc_t'(CYCLES_PER_SEC);
    localparam cyc_t LAST_CYC = cyc_t'(CYCLES_PER_SEC - 1);

    tb_op_e op;
    tod_t   tod_d;

    always_comb begin
        if (set_stb)
            op = OP_SET;
        else if (!en)
            op = OP_HOLD;
        else if (tod_q.cyc == LAST_CYC)
            op = adj_pend ? OP_ROLL_ADJ : OP_ROLL;
        else
            op = OP_RUN;
    end

    always_comb begin
        tod_d = tod_q;
        case (op)
            OP_SET:      tod_d = set_val;
            OP_RUN:      tod_d.cyc = tod_q.cyc + cyc_t'(1);
            OP_ROLL: begin
                tod_d.cyc = '0;
                tod_d.sec = tod_q.sec + sec_t'(1);
            end
            OP_ROLL_ADJ: tod_d = roll_with_offset(tod_q.sec, adj_val, LIMIT);
            default:     tod_d = tod_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            tod_q <= '0;
        else
            tod_q <= tod_d;
    end

    assign adj_applied = (op == OP_ROLL_ADJ);
    assign zero_load   = (op != OP_HOLD) && (op != OP_RUN) && (tod_d.cyc == '0);

    // R2
    cyc_range_chk: assert property (@(posedge clk) disable iff (rst)
        tod_q.cyc <= LAST_CYC);

    // R2
    run_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !set_stb && tod_q.cyc != LAST_CYC)
        |=> (tod_q.cyc == $past(tod_q.cyc) + cyc_t'(1)) && $stable(tod_q.sec));

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !set_stb && !adj_pend && tod_q.cyc == LAST_CYC)
        |=> (tod_q.cyc == '0) && (tod_q.sec == $past(tod_q.sec) + sec_t'(1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !set_stb) |=> $stable(tod_q));

    // R4
    set_load_chk: assert property (@(posedge clk) disable iff (rst)
        set_stb |=> (tod_q == $past(set_val)));

endmodule

// File: rtl/ppsg_adj_ctrl.sv
module ppsg_adj_ctrl
    import ppsg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adj_req,
    input  logic set_req,
    input  logic applied,
    input  tod_t req_delta,
    output logic busy,
    output tod_t delta
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            delta <= '0;
        end else if (set_req || applied) begin
            busy <= 1'b0;
        end else if (adj_req && !busy) begin
            busy  <= 1'b1;
            delta <= req_delta;
        end
    end

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (adj_req && !busy && !set_req) |=> busy && (delta == $past(req_delta)));

    // R5
    keep_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !applied && !set_req) |=> busy && $stable(delta));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        (applied || set_req) |=> !busy);

endmodule

// File: rtl/ppsg_pulse_shaper.sv
module ppsg_pulse_shaper #(
    parameter int PW_W = 28
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [PW_W-1:0] width,
    output logic            pulse
);

    logic [PW_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= width;
        else if (remain != '0)
            remain <= remain - PW_W'(1);
    end

    assign pulse = (remain != '0);

    // R8
    start_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (pulse == ($past(width) != '0)));

    // R8
    end_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && remain <= PW_W'(1)) |=> !pulse);

    // R8
    rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> $past(start));

endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
    import ppsg_pkg::*;
#(
    parameter int unsigned CYCLES_PER_SEC = 125_000_000,
    parameter int          PW_W           = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic [PW_W-1:0]     pulse_width,
    input  logic                set_req,
    input  logic                adj_req,
    input  logic [SEC_LO_W-1:0] shadow_sec_lo,
    input  logic [SEC_HI_W-1:0] shadow_sec_hi,
    input  logic [CYC_W-1:0]    shadow_cyc,
    output logic [SEC_W-1:0]    sec_o,
    output logic [CYC_W-1:0]    cyc_o,
    output logic                pps_o,
    output logic                busy_o
);

    tod_t shadow;
    tod_t tod;
    tod_t pend_delta;
    logic applied;
    logic zero_load;
    logic busy;

    assign shadow.sec = {shadow_sec_hi, shadow_sec_lo};
    assign shadow.cyc = shadow_cyc;

    ppsg_adj_ctrl u_adj (
        .clk       (clk),
        .rst       (rst),
        .adj_req   (adj_req),
        .set_req   (set_req),
        .applied   (applied),
        .req_delta (shadow),
        .busy      (busy),
        .delta     (pend_delta)
    );

    ppsg_timebase #(.CYCLES_PER_SEC(CYCLES_PER_SEC)) u_tb (
        .clk         (clk),
        .rst         (rst),
        .en          (cnt_en),
        .set_stb     (set_req),
        .set_val     (shadow),
        .adj_pend    (busy),
        .adj_val     (pend_delta),
        .tod_q       (tod),
        .adj_applied (applied),
        .zero_load   (zero_load)
    );

    ppsg_pulse_shaper #(.PW_W(PW_W)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .start (zero_load),
        .width (pulse_width),
        .pulse (pps_o)
    );

    assign sec_o  = tod.sec;
    assign cyc_o  = tod.cyc;
    assign busy_o = busy;

    // R9
    pulse_align_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pps_o) |-> (cyc_o == '0));

    // R4
    set_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        set_req |=> !busy_o);

endmodule

// File: tb/test_pps_timekeeper.sv
module test_pps_timekeeper;

    localparam int unsigned L = 50;
    localparam int PW_W = 28;

    logic            clk = 1'b0;
    logic            rst;
    logic            cnt_en;
    logic [PW_W-1:0] pw;
    logic            set_req;
    logic            adj_req;
    logic [31:0]     sh_lo;
    logic [7:0]      sh_hi;
    logic [27:0]     sh_cyc;
    logic [39:0]     sec_o;
    logic [27:0]     cyc_o;
    logic            pps_o;
    logic            busy_o;

    always #5 clk = ~clk;

    pps_timekeeper #(.CYCLES_PER_SEC(L), .PW_W(PW_W)) i_pps_timekeeper (
        .clk           (clk),
        .rst           (rst),
        .cnt_en        (cnt_en),
        .pulse_width   (pw),
        .set_req       (set_req),
        .adj_req       (adj_req),
        .shadow_sec_lo (sh_lo),
        .shadow_sec_hi (sh_hi),
        .shadow_cyc    (sh_cyc),
        .sec_o         (sec_o),
        .cyc_o         (cyc_o),
        .pps_o         (pps_o),
        .busy_o        (busy_o)
    );

    typedef struct {
        string       tag;
        logic [39:0] sec;
        logic [27:0] cyc;
        logic        pps;
        logic        busy;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference model state
    logic [39:0]     m_sec, m_dsec;
    logic [27:0]     m_cyc, m_dcyc;
    logic [PW_W-1:0] m_pw;
    logic            m_busy;

    task automatic tick(input string tag);
        exp_t e;
        logic st;
        logic old_busy;
        st = 1'b0;
        old_busy = m_busy;
        if (rst) begin
            m_sec = '0; m_cyc = '0; m_busy = 1'b0; m_dsec = '0; m_dcyc = '0;
        end else if (set_req) begin
            m_sec  = {sh_hi, sh_lo};
            m_cyc  = sh_cyc;
            m_busy = 1'b0;
            st     = (sh_cyc == 28'd0);
        end else begin
            if (cnt_en) begin
                if (m_cyc == 28'(L - 1)) begin
                    if (m_busy) begin
                        m_sec = m_sec + 40'd1 + m_dsec;
                        if (m_dcyc[27]) begin
                            m_cyc = 28'(L) + m_dcyc;
                            m_sec = m_sec - 40'd1;
                        end else begin
                            m_cyc = m_dcyc;
                        end
                        m_busy = 1'b0;
                    end else begin
                        m_sec = m_sec + 40'd1;
                        m_cyc = '0;
                    end
                    st = (m_cyc == 28'd0);
                end else begin
                    m_cyc = m_cyc + 28'd1;
                end
            end
            if (adj_req && !old_busy) begin
                m_busy = 1'b1;
                m_dsec = {sh_hi, sh_lo};
                m_dcyc = sh_cyc;
            end
        end
        if (rst)
            m_pw = '0;
        else if (st)
            m_pw = pw;
        else if (m_pw != '0)
            m_pw = m_pw - 1'b1;
        e.tag  = tag;
        e.sec  = m_sec;
        e.cyc  = m_cyc;
        e.pps  = (m_pw != '0);
        e.busy = m_busy;
        q.push_back(e);
        @(posedge clk);
        #2;
    endtask

    task automatic do_set(input string tag, input logic [39:0] s, input logic [27:0] c);
        {sh_hi, sh_lo} = s;
        sh_cyc  = c;
        set_req = 1'b1;
        tick(tag);
        set_req = 1'b0;
    endtask

    task automatic do_adj(input string tag, input logic [39:0] s, input logic [27:0] c);
        {sh_hi, sh_lo} = s;
        sh_cyc  = c;
        adj_req = 1'b1;
        tick(tag);
        adj_req = 1'b0;
    endtask

    task automatic run_to(input string tag, input logic [27:0] target);
        while (m_cyc != target) tick(tag);
    endtask

    // Monitor: compares design outputs with the scoreboard queue
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (sec_o !== e.sec || cyc_o !== e.cyc || pps_o !== e.pps || busy_o !== e.busy) begin
                n_fail++;
                $display("FAIL %s: actual sec=%h cyc=%0d pps=%b busy=%b expected sec=%h cyc=%0d pps=%b busy=%b",
                         e.tag, sec_o, cyc_o, pps_o, busy_o, e.sec, e.cyc, e.pps, e.busy);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cnt_en = 1'b0; pw = '0; set_req = 1'b0; adj_req = 1'b0;
        sh_lo = '0; sh_hi = '0; sh_cyc = '0;
        m_sec = '0; m_cyc = '0; m_dsec = '0; m_dcyc = '0; m_pw = '0; m_busy = 1'b0;
        #2;
        repeat (3) tick("R1 reset");
        rst = 1'b0;
        tick("R1 after reset");
        pw = 28'd5; cnt_en = 1'b1;
        repeat (120) tick("R2 R8 free run");
        cnt_en = 1'b0;
        repeat (10) tick("R3 hold");
        cnt_en = 1'b1;
        do_set("R4 R9 set to zero", 40'h12_3456_789A, 28'd0);
        repeat (60) tick("R9 run after set");
        do_set("R4 set mid second", 40'h00_0000_0100, 28'd10);
        repeat (5) tick("R4 run");
        do_adj("R5 adjust capture", 40'd3, 28'd7);
        repeat (3) tick("R5 busy");
        do_adj("R5 ignored while busy", 40'd100, 28'd20);
        repeat (60) tick("R6 positive offset");
        do_adj("R7 negative offset", 40'hFF_FFFF_FFFF, 28'hFFF_FFFB);
        repeat (60) tick("R7 borrow");
        do_adj("R9 zero offset", 40'd0, 28'd0);
        repeat (60) tick("R9 pulse on adjust");
        pw = 28'd0;
        repeat (60) tick("R8 zero width");
        pw = 28'd5;
        run_to("R8 wait", 28'd1);
        pw = 28'd20;
        repeat (80) tick("R8 width sampled at start");
        pw = 28'd5;
        do_adj("R4 adjust before set", 40'd5, 28'd0);
        repeat (2) tick("R4 pending");
        do_set("R4 set cancels adjust", 40'h50, 28'd20);
        repeat (60) tick("R4 cancelled");
        do_adj("R4 arm adjust", 40'd9, 28'd3);
        run_to("R4 approach rollover", 28'(L - 1));
        do_set("R4 set beats rollover", 40'h77, 28'd30);
        repeat (60) tick("R4 after collision");
        adj_req = 1'b1;
        do_set("R4 set beats adjust", 40'h99, 28'd12);
        adj_req = 1'b0;
        repeat (60) tick("R4 no adjust");
        do_set("R2 near seconds wrap", 40'hFF_FFFF_FFFF, 28'd45);
        repeat (10) tick("R2 seconds wrap");
        do_adj("R3 adjust armed", 40'd2, 28'd0);
        cnt_en = 1'b0;
        repeat (60) tick("R3 adjust waits while disabled");
        cnt_en = 1'b1;
        repeat (60) tick("R6 applied after enable");
        @(negedge clk);
        #1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule